// File: doc/BRIEF.md
# IDE Channel Register Window Filter

This block sits between a host I/O decoder and the register interface of one IDE channel. The host reaches the channel through two windows. The first is an 8-byte task-file window that also holds the data port. The second is a 4-byte control window. For each host access the filter checks both the window offset and the access width. It then either forwards the access to the downstream register interface or drops it.

A forwarded access raises exactly one read or write strobe towards the device side, one clock after the request. The strobe carries a register select, a width code and little-endian data. A dropped write raises no strobe at all. A dropped read returns all ones for the width of the access. Every access is acknowledged two clocks after the request, whether it was accepted or not, so the host cannot tell the outcome from the timing.

Top module: `ide_window_filter`

## Requirements
- R1: While reset is high and on the first clock after it, `dev_rd`, `dev_wr` and `host_ack` are low and `host_rdata` is zero.
- R2: In the control window (`host_sel_ctl`=1), only a 1-byte access (`host_size`=0) with `host_addr[1:0]`=2 is forwarded. It goes out with `dev_reg`=8 and `dev_width`=0. Only `host_addr[1:0]` is decoded in this window.
- R3: A control-window read at any other offset or width completes with all ones of the access width: 0xFF for size 0, 0xFFFF for size 1, 0xFFFFFFFF for size 2. No strobe is raised.
- R4: A control-window write at any other offset or width raises no downstream strobe. The stored register contents stay unchanged.
- R5: In the data window (`host_sel_ctl`=0), a 1-byte access at any offset 0..7 is forwarded with `dev_reg` equal to that offset and `dev_width`=0.
- R6: In the data window, a 2-byte access (size 1) or a 4-byte access (size 2) at offset 0 is forwarded with `dev_reg`=0 and `dev_width` equal to the size code.
- R7: In the data window, a 2-byte or 4-byte access at a nonzero offset is rejected. A read returns all ones of its width. A write raises no strobe.
- R8: Size code 3 is reserved. It is rejected in both windows, and a read of that kind returns 0xFFFFFFFF.
- R9: An accepted access gives exactly one `dev_rd` or `dev_wr` pulse, in the clock after the request. Every access, accepted or not, gives exactly one `host_ack` pulse two clocks after the request.
- R10: Data is little-endian and right-aligned. A byte sits in bits [7:0] and a halfword in bits [15:0]. Bits above the access width read as zero on `host_rdata` and are driven as zero on `dev_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read request, one cycle per access |
| host_wr | input | 1 | Host write request, one cycle per access |
| host_sel_ctl | input | 1 | Window select: 0 task-file/data window, 1 control window |
| host_addr | input | 3 | Byte offset within the selected window |
| host_size | input | 2 | Width code: 0 byte, 1 halfword, 2 word, 3 reserved |
| host_wdata | input | 32 | Write data, right-aligned |
| host_ack | output | 1 | Access completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_ack` of a read |
| dev_rd | output | 1 | Downstream read strobe |
| dev_wr | output | 1 | Downstream write strobe |
| dev_reg | output | 4 | Register select: 0..7 task file, 8 device control |
| dev_width | output | 2 | Width code of the forwarded access |
| dev_wdata | output | 32 | Masked write data |
| dev_rdata | input | 32 | Combinational read data from the register stub |

## Verification
The assertions assume that the host never raises `host_rd` and `host_wr` in the same cycle. They also assume that both request lines stay low while reset is high. The stimulus keeps to this: every bench step drives at most one request line, and all request lines are held low through reset. The bench also assumes the device answers reads combinationally from the registered select. Its register stub is built that way.

// File: rtl/ide_filt_pkg.sv
package ide_filt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      rd;
    logic      wr;
    logic      accept;
    logic [3:0] rsel;
    acc_size_e size;
  } req_info_t;

  // Ones covering the access width; reserved code covers the full bus.
  function automatic logic [31:0] width_mask(input acc_size_e sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_filt_pkg::*;
#(
  parameter int AW      = 3,
  parameter int RSEL_W  = 4,
  parameter int CTL_OFS = 2,
  parameter int CTL_REG = 8
) (
  input  logic              sel_ctl,
  input  logic [AW-1:0]     addr,
  input  acc_size_e         size,
  output logic              accept,
  output logic [RSEL_W-1:0] rsel
);
  localparam int CTL_AW = 2;

  logic ctl_ok;
  logic data_ok;

  always_comb begin
    ctl_ok = (size == SZ_BYTE) &&
             (addr[CTL_AW-1:0] == CTL_AW'(CTL_OFS));
    case (size)
      SZ_BYTE:          data_ok = 1'b1;
      SZ_HALF, SZ_WORD: data_ok = (addr == '0);
      default:          data_ok = 1'b0;
    endcase
    accept = sel_ctl ? ctl_ok : data_ok;
    rsel   = sel_ctl ? RSEL_W'(CTL_REG) : RSEL_W'(addr);
  end
endmodule

// File: rtl/ide_fwd_stage.sv
module ide_fwd_stage
  import ide_filt_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              accept,
  input  logic [RSEL_W-1:0] rsel,
  input  acc_size_e         size,
  input  logic [DW-1:0]     wdata,
  output req_info_t         info,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [RSEL_W-1:0] dev_reg,
  output logic [1:0]        dev_width,
  output logic [DW-1:0]     dev_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      info      <= '0;
      dev_rd    <= 1'b0;
      dev_wr    <= 1'b0;
      dev_reg   <= '0;
      dev_width <= 2'd0;
      dev_wdata <= '0;
    end else begin
      info.rd     <= req_rd;
      info.wr     <= req_wr;
      info.accept <= accept;
      info.rsel   <= 4'(rsel);
      info.size   <= size;
      dev_rd      <= req_rd & accept;
      dev_wr      <= req_wr & accept;
      if ((req_rd | req_wr) && accept) begin
        dev_reg   <= rsel;
        dev_width <= size;
        dev_wdata <= wdata & DW'(width_mask(size));
      end
    end
  end
endmodule

// File: rtl/ide_resp_stage.sv
module ide_resp_stage
  import ide_filt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  req_info_t     info,
  input  logic [DW-1:0] dev_rdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata
);
  logic [DW-1:0] mask;
  logic [DW-1:0] rd_val;

  always_comb begin
    mask   = DW'(width_mask(info.size));
    rd_val = info.accept ? (dev_rdata & mask) : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= info.rd | info.wr;
      if (info.rd) host_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/ide_window_filter.sv
module ide_window_filter
  import ide_filt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int RSEL_W  = 4,
  parameter int CTL_OFS = 2,
  parameter int CTL_REG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_sel_ctl,
  input  logic [AW-1:0]     host_addr,
  input  logic [1:0]        host_size,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_ack,
  output logic [DW-1:0]     host_rdata,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [RSEL_W-1:0] dev_reg,
  output logic [1:0]        dev_width,
  output logic [DW-1:0]     dev_wdata,
  input  logic [DW-1:0]     dev_rdata
);
  acc_size_e         size_c;
  logic              accept;
  logic [RSEL_W-1:0] rsel;
  req_info_t         info;

  assign size_c = acc_size_e'(host_size);

  ide_win_decode #(
    .AW(AW), .RSEL_W(RSEL_W), .CTL_OFS(CTL_OFS), .CTL_REG(CTL_REG)
  ) u_dec (
    .sel_ctl(host_sel_ctl), .addr(host_addr), .size(size_c),
    .accept(accept), .rsel(rsel)
  );

  ide_fwd_stage #(.DW(DW), .RSEL_W(RSEL_W)) u_fwd (
    .clk(clk), .rst(rst), .req_rd(host_rd), .req_wr(host_wr),
    .accept(accept), .rsel(rsel), .size(size_c), .wdata(host_wdata),
    .info(info), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_reg(dev_reg),
    .dev_width(dev_width), .dev_wdata(dev_wdata)
  );

  ide_resp_stage #(.DW(DW)) u_resp (
    .clk(clk), .rst(rst), .info(info), .dev_rdata(dev_rdata),
    .host_ack(host_ack), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/ide_window_filter_chk.sv
module ide_window_filter_chk #(
  parameter int DW     = 32,
  parameter int RSEL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rd,
  input logic              host_wr,
  input logic              host_ack,
  input logic              dev_rd,
  input logic              dev_wr,
  input logic [RSEL_W-1:0] dev_reg,
  input logic [1:0]        dev_width
);
  // R9: one strobe kind at a time
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(dev_rd && dev_wr));
  // R9: every request is acknowledged two clocks later
  a_r9_ack_follows: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) |=> ##1 host_ack);
  // R9: a read strobe only follows a read request
  a_r9_rd_from_req: assert property (@(posedge clk) disable iff (rst)
    dev_rd |-> $past(host_rd));
  // R9: a write strobe only follows a write request
  a_r9_wr_from_req: assert property (@(posedge clk) disable iff (rst)
    dev_wr |-> $past(host_wr));
  // R2: the control register is reached only by byte accesses
  a_r2_ctl_byte: assert property (@(posedge clk) disable iff (rst)
    ((dev_rd || dev_wr) && dev_reg == RSEL_W'(8)) |-> dev_width == 2'd0);
  // R6: wide transfers are forwarded only at the data register
  a_r6_wide_at_zero: assert property (@(posedge clk) disable iff (rst)
    ((dev_rd || dev_wr) && dev_width != 2'd0) |-> dev_reg == '0);
  // R8: the reserved width is never forwarded
  a_r8_no_rsvd: assert property (@(posedge clk) disable iff (rst)
    (dev_rd || dev_wr) |-> dev_width != 2'd3);
endmodule

bind ide_window_filter ide_window_filter_chk #(.DW(DW), .RSEL_W(RSEL_W)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
  .host_ack(host_ack), .dev_rd(dev_rd), .dev_wr(dev_wr),
  .dev_reg(dev_reg), .dev_width(dev_width)
);

// File: tb/tb_ide_window_filter.sv
module tb_ide_window_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_rd = 0, host_wr = 0, host_sel_ctl = 0;
  logic [2:0]  host_addr = 0;
  logic [1:0]  host_size = 0;
  logic [31:0] host_wdata = 0;
  logic        host_ack, dev_rd, dev_wr;
  logic [31:0] host_rdata, dev_wdata, dev_rdata;
  logic [3:0]  dev_reg;
  logic [1:0]  dev_width;

  always #4 clk = ~clk;   // 125 MHz

  ide_window_filter dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_sel_ctl(host_sel_ctl), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_reg(dev_reg), .dev_width(dev_width),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  // Register stub: nine registers, combinational read.
  logic [31:0] stub [0:8];
  assign dev_rdata = (dev_reg <= 4'd8) ? stub[dev_reg] : 32'h0;
  always_ff @(posedge clk) begin
    if (dev_wr && dev_reg <= 4'd8) stub[dev_reg] <= dev_wdata;
  end

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] shadow [0:8];

  typedef struct {
    bit        valid, rd, wr, acc;
    int        rsel;
    int        size;
    logic [31:0] wd, exp;
    int        tag;
  } rec_t;
  rec_t p1, p2;

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // Compare against model: dev side for p1, host side for p2; then drive.
  task automatic step(input bit rd, input bit wr, input bit ctl,
                      input int addr, input int sz, input logic [31:0] wd,
                      input int tag_ovr);
    rec_t n;
    bit ctl_ok, dat_ok;
    @(negedge clk);
    // R9: strobes one clock after request
    chk(dev_rd == (p1.valid && p1.rd && p1.acc), p1.tag, "dev_rd", 32'(dev_rd),
        32'(p1.valid && p1.rd && p1.acc));
    chk(dev_wr == (p1.valid && p1.wr && p1.acc), p1.tag, "dev_wr", 32'(dev_wr),
        32'(p1.valid && p1.wr && p1.acc));
    if (p1.valid && p1.acc) begin
      chk(dev_reg == 4'(p1.rsel), p1.tag, "dev_reg", 32'(dev_reg), 32'(p1.rsel));
      chk(dev_width == 2'(p1.size), p1.tag, "dev_width", 32'(dev_width), 32'(p1.size));
      if (p1.wr) chk(dev_wdata == (p1.wd & mk(p1.size)), p1.tag, "dev_wdata",
                     dev_wdata, p1.wd & mk(p1.size));
    end
    // R9: ack two clocks after request
    chk(host_ack == p2.valid, 9, "host_ack", 32'(host_ack), 32'(p2.valid));
    if (p2.valid && p2.rd)
      chk(host_rdata == p2.exp, p2.tag, "host_rdata", host_rdata, p2.exp);
    p2 = p1;
    n.valid = rd | wr; n.rd = rd; n.wr = wr; n.size = sz; n.wd = wd;
    ctl_ok = (sz == 0) && ((addr & 3) == 2);
    dat_ok = (sz == 0) || ((sz == 1 || sz == 2) && addr == 0);
    n.acc  = ctl ? ctl_ok : dat_ok;
    n.rsel = ctl ? 8 : addr;
    if (sz == 3) n.tag = 8;                       // R8
    else if (ctl) n.tag = ctl_ok ? 2 : (rd ? 3 : 4); // R2 R3 R4
    else if (sz == 0) n.tag = 5;                  // R5
    else n.tag = dat_ok ? 6 : 7;                  // R6 R7
    if (tag_ovr != 0) n.tag = tag_ovr;
    n.exp = n.acc ? (shadow[n.rsel] & mk(sz)) : mk(sz);
    if (wr && n.acc) shadow[n.rsel] = wd & mk(sz);
    p1 = n;
    host_rd = rd; host_wr = wr; host_sel_ctl = ctl;
    host_addr = 3'(addr); host_size = 2'(sz); host_wdata = wd;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL R9 watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i <= 8; i++) begin stub[i] = 32'h0; shadow[i] = 32'h0; end
    p1 = '{default: 0}; p2 = '{default: 0};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!dev_rd && !dev_wr && !host_ack && host_rdata == 0, 1, "reset outputs",
        {host_rdata[28:0], dev_rd, dev_wr, host_ack}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(!dev_rd && !dev_wr && !host_ack && host_rdata == 0, 1, "first cycle",
        {host_rdata[28:0], dev_rd, dev_wr, host_ack}, 32'h0);

    // R10: little-endian placement of a word, then narrow reads
    step(0, 1, 0, 0, 2, 32'hA1B2_C3D4, 10);
    step(1, 0, 0, 0, 0, 0, 10);
    step(1, 0, 0, 0, 1, 0, 10);
    step(1, 0, 0, 0, 2, 0, 10);
    // R4: control writes at wrong place leave control register alone
    step(0, 1, 1, 2, 0, 32'h5A, 2);
    step(0, 1, 1, 1, 0, 32'hFF, 4);
    step(0, 1, 1, 2, 1, 32'hFFFF, 4);
    step(1, 0, 1, 2, 0, 0, 4);
    // Sweep: every window, offset, width, direction, back-to-back.
    for (int rep = 0; rep < 3; rep++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 8; a++)
          for (int s = 0; s < 4; s++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(0, 1, w[0], a, s, lfsr, 0);
            step(1, 0, w[0], a, s, 0, 0);
            if (lfsr[3]) step(0, 0, 0, 0, 0, 0, 0);
          end
    // R5: each task-file byte written then read back in one pass
    for (int a = 0; a < 8; a++) step(0, 1, 0, a, 0, 32'h1234_5600 + a, 5);
    for (int a = 0; a < 8; a++) step(1, 0, 0, a, 0, 0, 5);
    // R7: wide data read at nonzero offset
    step(1, 0, 0, 4, 2, 0, 7);
    step(1, 0, 0, 2, 1, 0, 7);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule